// File: doc/BRIEF.md
# RISC Integer Execute Unit

This block is the integer execute stage of a 32-bit, three-operand load/store RISC pipeline. A decoder upstream hands it an operation code, the two source register values, the 5-bit shift-amount field and the 16-bit immediate field of the instruction. The block returns one result word and a zero flag. The equality branch logic uses the zero flag.

It covers add, subtract, AND, OR, NOR, signed set-on-less-than, logical shifts by a constant and the upper-immediate load. Each of these comes in register or immediate form where the instruction set has one. Add-immediate and the immediate compare sign-extend their constant. AND-immediate and OR-immediate zero-extend it. With the default setting, the result and the flag are registered, so they appear one clock after the inputs.

Top module: `rix_exec_unit`

## Requirements
- R1: Code 0 (add) returns A + B. Code 1 (add-immediate) returns A plus the sign-extended 16-bit immediate. Both wrap modulo 2^32.
- R2: Code 2 (subtract) returns A - B, modulo 2^32.
- R3: Codes 3 and 5 return A AND B and A OR B. Codes 4 and 6 return A AND / A OR the immediate zero-extended to 32 bits.
- R4: Code 7 returns NOT (A OR B). With B = 0 this gives NOT A.
- R5: Code 8 returns the word 1 when A < B as signed two's complement values, and 0 otherwise. Code 9 does the same against the sign-extended immediate.
- R6: Codes 10 and 11 shift B left and right, logically, by shamt (0 to 31). Vacated bits fill with zeros.
- R7: Code 12 returns the immediate in bits 31:16, with zeros in bits 15:0.
- R8: An upper-immediate result fed back as A to code 6 (OR-immediate) yields the full 32-bit constant with its upper half unchanged.
- R9: For every code, zero_flag is 1 exactly when A - B equals 0.
- R10: result and zero_flag change on the first rising clock edge after the inputs. With rst_n low at a rising edge, both become 0.
- R11: Codes 13 to 15 give result 0. zero_flag still follows R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 4 | Operation code (see R1-R7, R11) |
| opnd_a | input | 32 | First source value (rs) |
| opnd_b | input | 32 | Second source value (rt), also the shift input |
| shamt | input | 5 | Shift amount |
| imm | input | 16 | Immediate field |
| result | output | 32 | Operation result |
| zero_flag | output | 1 | A - B is zero |

## Verification
Every code, including the three unused ones, is applied to every pair from a set of corner words: 0, 1, all ones, both signed extremes and alternating patterns. Each pair is also combined with immediates on both sides of the sign bit. These pairs separate sign extension from zero extension, and separate a signed compare from an unsigned one. They also expose wraparound at the signed boundary, where a plain subtraction sign would give the wrong order. Both shift directions are swept over all 32 amounts to catch a wrong fill or an off-by-one stage. Random operands then cover the general arithmetic. Fixed sequences check the upper-immediate then OR-immediate constant build, the one-cycle latency and the reset clearing.

// File: rtl/rix_pkg.sv
`timescale 1ns/1ps
// Package: operation codes shared by the execute unit and its bench.
// Assumes a 4-bit code; unused values decode to a zero result.
package rix_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDI = 4'd1,
        OP_SUB  = 4'd2,
        OP_AND  = 4'd3,
        OP_ANDI = 4'd4,
        OP_OR   = 4'd5,
        OP_ORI  = 4'd6,
        OP_NOR  = 4'd7,
        OP_SLT  = 4'd8,
        OP_SLTI = 4'd9,
        OP_SLL  = 4'd10,
        OP_SRL  = 4'd11,
        OP_LUI  = 4'd12
    } rix_op_e;
endpackage

// File: rtl/rix_imm_ext.sv
`timescale 1ns/1ps
// Module: rix_imm_ext
// Widens the instruction immediate to the datapath width. Arithmetic forms
// sign-extend, logical forms zero-extend, and the upper-immediate form places
// the constant in the top bits. Assumes WIDTH > IMMW.
module rix_imm_ext
    import rix_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMMW  = 16
) (
    input  rix_op_e          op,
    input  logic [IMMW-1:0]  imm,
    output logic [WIDTH-1:0] imm_val
);
    localparam int EXTW = WIDTH - IMMW;

    // Select extension style from the operation.
    always_comb begin
        case (op)
            OP_ADDI, OP_SLTI: imm_val = {{EXTW{imm[IMMW-1]}}, imm};
            OP_LUI:           imm_val = {imm, {EXTW{1'b0}}};
            default:          imm_val = {{EXTW{1'b0}}, imm};
        endcase
    end
endmodule

// File: rtl/rix_addsub.sv
`timescale 1ns/1ps
// Module: rix_addsub
// Adder, subtractor and signed less-than. Less-than is taken from the
// subtractor sign corrected by overflow. A separate A-B difference feeds the
// zero flag, since the second operand may be an immediate.
module rix_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] src2,
    output logic [WIDTH-1:0] sum,
    output logic [WIDTH-1:0] diff,
    output logic             lt,
    output logic             ab_zero
);
    localparam int MSB = WIDTH - 1;
    logic             ovf;
    logic [WIDTH-1:0] ab_diff;

    // Sum, difference and signed compare against the selected operand.
    always_comb begin
        sum  = a + src2;
        diff = a - src2;
        ovf  = (a[MSB] ^ src2[MSB]) & (a[MSB] ^ diff[MSB]);
        lt   = diff[MSB] ^ ovf;
    end

    // Register-register difference for the branch zero flag.
    always_comb begin
        ab_diff = a - b;
        ab_zero = (ab_diff == '0);
    end
endmodule

// File: rtl/rix_logic_shift.sv
`timescale 1ns/1ps
// Module: rix_logic_shift
// Bitwise AND/OR/NOR and a logarithmic logical shifter in both directions.
// Shift stage k moves by 2**k when shamt bit k is set; zeros fill.
module rix_logic_shift #(
    parameter int WIDTH = 32,
    parameter int SHW   = 5
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] src2,
    input  logic [WIDTH-1:0] rt,
    input  logic [SHW-1:0]   shamt,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o,
    output logic [WIDTH-1:0] nor_o,
    output logic [WIDTH-1:0] sll_o,
    output logic [WIDTH-1:0] srl_o
);
    logic [WIDTH-1:0] stg_l [SHW+1];
    logic [WIDTH-1:0] stg_r [SHW+1];

    // Bitwise group.
    always_comb begin
        and_o = a & src2;
        or_o  = a | src2;
        nor_o = ~(a | src2);
    end

    assign stg_l[0] = rt;
    assign stg_r[0] = rt;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int DIST = 2 ** k;
        // One power-of-two step of each shifter.
        always_comb begin
            stg_l[k+1] = shamt[k] ? {stg_l[k][WIDTH-1-DIST:0], {DIST{1'b0}}} : stg_l[k];
            stg_r[k+1] = shamt[k] ? {{DIST{1'b0}}, stg_r[k][WIDTH-1:DIST]} : stg_r[k];
        end
    end

    assign sll_o = stg_l[SHW];
    assign srl_o = stg_r[SHW];
endmodule

// File: rtl/rix_exec_unit.sv
`timescale 1ns/1ps
// Module: rix_exec_unit
// Integer execute stage: picks the second operand (register or widened
// immediate), runs the arithmetic and logic/shift units, and selects the
// result. With REG_OUT=1 the result and zero flag are registered, with a
// synchronous active-low reset to zero. Assumes decoded inputs arrive
// together each cycle.
module rix_exec_unit
    import rix_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int IMMW    = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [3:0]               op_sel,
    input  logic [WIDTH-1:0]         opnd_a,
    input  logic [WIDTH-1:0]         opnd_b,
    input  logic [$clog2(WIDTH)-1:0] shamt,
    input  logic [IMMW-1:0]          imm,
    output logic [WIDTH-1:0]         result,
    output logic                     zero_flag
);
    localparam int SHW = $clog2(WIDTH);

    rix_op_e          op;
    logic             use_imm;
    logic [WIDTH-1:0] imm_val, src2;
    logic [WIDTH-1:0] sum, diff, and_v, or_v, nor_v, sll_v, srl_v;
    logic             lt, ab_zero;
    logic [WIDTH-1:0] next_res;

    assign op = rix_op_e'(op_sel);

    // Decide whether the second operand is the immediate.
    always_comb begin
        use_imm = (op == OP_ADDI) || (op == OP_ANDI) || (op == OP_ORI) || (op == OP_SLTI);
        src2    = use_imm ? imm_val : opnd_b;
    end

    rix_imm_ext #(.WIDTH(WIDTH), .IMMW(IMMW)) u_imm (
        .op(op), .imm(imm), .imm_val(imm_val)
    );

    rix_addsub #(.WIDTH(WIDTH)) u_arith (
        .a(opnd_a), .b(opnd_b), .src2(src2),
        .sum(sum), .diff(diff), .lt(lt), .ab_zero(ab_zero)
    );

    rix_logic_shift #(.WIDTH(WIDTH), .SHW(SHW)) u_lsh (
        .a(opnd_a), .src2(src2), .rt(opnd_b), .shamt(shamt),
        .and_o(and_v), .or_o(or_v), .nor_o(nor_v), .sll_o(sll_v), .srl_o(srl_v)
    );

    // Result select.
    always_comb begin
        case (op)
            OP_ADD, OP_ADDI: next_res = sum;
            OP_SUB:          next_res = diff;
            OP_AND, OP_ANDI: next_res = and_v;
            OP_OR, OP_ORI:   next_res = or_v;
            OP_NOR:          next_res = nor_v;
            OP_SLT, OP_SLTI: next_res = {{(WIDTH-1){1'b0}}, lt};
            OP_SLL:          next_res = sll_v;
            OP_SRL:          next_res = srl_v;
            OP_LUI:          next_res = imm_val;
            default:         next_res = '0;
        endcase
    end

    if (REG_OUT) begin : g_reg
        logic [WIDTH-1:0] res_q;
        logic             zero_q;

        // Output register with synchronous reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q  <= '0;
                zero_q <= 1'b0;
            end else begin
                res_q  <= next_res;
                zero_q <= ab_zero;
            end
        end
        assign result    = res_q;
        assign zero_flag = zero_q;

        p_zero_eq_r9: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (zero_flag == ($past(opnd_a) == $past(opnd_b))));
        p_lui_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_LUI) |=> (result[IMMW-1:0] == '0));
        p_slt_bool_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_SLT || op == OP_SLTI) |=> (result[WIDTH-1:1] == '0));
        p_shift_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_SLL && shamt == '0) |=> (result == $past(opnd_b)));
        p_nor_not_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_NOR && opnd_b == '0) |=> (result == ~$past(opnd_a)));
        p_andi_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_ANDI) |=> (result[WIDTH-1:IMMW] == '0));
    end else begin : g_comb
        assign result    = next_res;
        assign zero_flag = ab_zero;
    end
endmodule

// File: tb/test_rix_exec_unit.sv
`timescale 1ns/1ps
module test_rix_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = 4'd0;
    logic [31:0] opnd_a = 32'd5, opnd_b = 32'd5;
    logic [4:0]  shamt = 5'd0;
    logic [15:0] imm = 16'd0;
    logic [31:0] result;
    logic        zero_flag;
    int total = 0, bad = 0;

    always #2 clk = ~clk;

    rix_exec_unit i_rix_exec_unit (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .shamt(shamt), .imm(imm),
        .result(result), .zero_flag(zero_flag)
    );

    function automatic logic [31:0] model(input int code, input logic [31:0] a,
                                          input logic [31:0] b, input logic [4:0] s,
                                          input logic [15:0] i);
        logic [31:0] se, ze;
        se = {{16{i[15]}}, i};
        ze = {16'd0, i};
        case (code)
            0:  return a + b;
            1:  return a + se;
            2:  return a - b;
            3:  return a & b;
            4:  return a & ze;
            5:  return a | b;
            6:  return a | ze;
            7:  return ~(a | b);
            8:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            9:  return ($signed(a) < $signed(se)) ? 32'd1 : 32'd0;
            10: return b * (32'd1 << s);
            11: return b / (32'd1 << s);
            12: return i * 32'h10000;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag(input int code);
        case (code)
            0, 1:        return "R1";
            2:           return "R2";
            3, 4, 5, 6:  return "R3";
            7:           return "R4";
            8, 9:        return "R5";
            10, 11:      return "R6";
            12:          return "R7";
            default:     return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got_r, input logic [31:0] exp_r,
                         input logic got_z, input logic exp_z);
        total++;
        if (got_r !== exp_r || got_z !== exp_z) begin
            bad++;
            $display("FAIL %s: result=%h zero=%b expected result=%h zero=%b",
                     req, got_r, got_z, exp_r, exp_z);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge (one register).
    task automatic apply(input int code, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] s, input logic [15:0] i);
        op_sel = 4'(code); opnd_a = a; opnd_b = b; shamt = s; imm = i;
        @(negedge clk);
        check({tag(code), "/R9"}, result, model(code, a, b, s, i), zero_flag, a == b);
    endtask

    logic [31:0] corners [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                                 32'h7FFF_FFFF, 32'hAAAA_AAAA, 32'h5555_5555, 32'hFFFF_FFFC};
    logic [15:0] imms [4] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFEE};

    initial begin
        #(4 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: expired, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] hold;
        // R10: reset clears outputs even with A == B on the inputs.
        repeat (3) @(negedge clk);
        check("R10 reset", result, 32'd0, zero_flag, 1'b0);
        rst_n = 1'b1;

        // Corner sweep over every code, operand pair and immediate sign.
        for (int c = 0; c < 16; c++)
            for (int x = 0; x < 8; x++)
                for (int y = 0; y < 8; y++)
                    apply(c, corners[x], corners[y], 5'(x * 4 + y), imms[(x + y) % 4]);

        // R6: all shift amounts in both directions.
        for (int s = 0; s < 32; s++)
            for (int v = 2; v < 8; v++) begin
                apply(10, 32'h0, corners[v], 5'(s), 16'h0);
                apply(11, 32'h0, corners[v], 5'(s), 16'h0);
            end

        // R4: NOR with zero gives the complement.
        apply(7, 32'h1234_5678, 32'h0, 5'd0, 16'h0);
        check("R4 not", result, 32'hEDCB_A987, zero_flag, 1'b0);

        // Random operands for every code.
        for (int n = 0; n < 300; n++)
            for (int c = 0; c < 16; c++)
                apply(c, $urandom, (n % 5 == 0) ? 32'h0 : $urandom, 5'($urandom), 16'($urandom));

        // R8: upper-immediate then OR-immediate builds the full constant.
        apply(12, 32'h0, 32'h0, 5'd0, 16'hAAAA);
        hold = result;
        apply(6, hold, 32'h0, 5'd0, 16'h5555);
        check("R8 constant", result, 32'hAAAA_5555, zero_flag, 1'b0);

        // R10: output holds until the next rising edge.
        op_sel = 4'd0; opnd_a = 32'd10; opnd_b = 32'd20;
        #1;
        check("R10 hold", result, 32'hAAAA_5555, zero_flag, 1'b0);
        @(negedge clk);
        check("R10 latency", result, 32'd30, zero_flag, 1'b0);

        // R10: reset asserted mid-run clears on the next edge.
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset again", result, 32'd0, zero_flag, 1'b0);
        rst_n = 1'b1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule